// File: doc/BRIEF.md
# Bit-Serial Arithmetic and Logic Core

This block does all of a small serial machine's arithmetic and logic with one single-bit datapath. An operation request carries an opcode, an accumulator word A, a memory word B and a short constant K. The request is accepted whole and loaded in parallel into two operand shift registers. The core then produces the result one bit per accepted beat, least significant bit first. Each operand passes through its own XOR inverter before one full adder. A carry flip-flop passes each bit's carry out into the next bit, so every operation is a sum of a possibly complemented A, a possibly complemented B (or K, or zero) and a preset carry. AND, OR and XOR are taken from the gates of the same slice.

Requests enter on a valid/ready channel. The result leaves on a second valid/ready channel, one bit per transfer, with a last marker on the final bit. A request is accepted only when no packet is in progress. When the consumer holds `res_ready` low, the core freezes: no shift, no carry update and no count. The bit and the last marker on the port stay as they are until the transfer completes. The carry out of an arithmetic packet is kept as a carry flag, which feeds the add-with-carry and subtract-with-borrow operations of a later packet.

Top module: `serial_alu_core`

## Requirements
- R1: After reset, `in_ready` is 1, `res_valid` is 0 and `carry_flag` is 0.
- R2: `in_ready` is high exactly when no packet is in progress. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` stays low until the final result bit has been transferred, and is high again in the next cycle.
- R3: In the cycle after an accepted request, `res_valid` is high. The W result bits then come out LSB first, one per transfer (`res_valid` and `res_ready` both high), and `res_last` is high on the W-th bit only.
- R4: While `res_valid` is high and `res_ready` is low, the next cycle still shows `res_valid` high with the same `res_bit` and `res_last`.
- R5: Opcode 0 (add) gives A+B mod 2^W with carry-in 0. Opcode 1 (subtract) gives A+~B+1. In both cases `carry_flag` is set to the final carry, so after a subtract it is 1 exactly when A >= B (unsigned).
- R6: Opcode 2 (add with carry) gives A+B+carry_flag. Opcode 3 (subtract with borrow) gives A+~B+carry_flag. Both take the flag as it stood before the request and update it with the final carry.
- R7: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B, and leave `carry_flag` unchanged.
- R8: Opcode 7 gives the ones' complement ~A, ignores B and clears `carry_flag`.
- R9: Opcode 8 gives A+K and opcode 9 gives A+~K+1, where K is `in_k` zero-extended to W bits. B is ignored, and `carry_flag` takes the final carry.
- R10: `carry_flag` changes only on the clock edge that transfers the final bit of a packet.
- R11: Opcodes 10 to 15 behave as opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Core idle, request can be taken |
| in_op | input | 4 | Operation code |
| in_a | input | W | Accumulator operand |
| in_b | input | W | Memory operand |
| in_k | input | KW | Short constant for increment/decrement |
| res_valid | output | 1 | A result bit is offered |
| res_ready | input | 1 | Consumer takes the offered bit |
| res_bit | output | 1 | Current result bit |
| res_last | output | 1 | Offered bit is bit W-1 |
| carry_flag | output | 1 | Final carry of the last arithmetic packet |

## Verification
Every opcode is driven with operand pairs that separate carry behaviour: operands with no carries at all, a full carry ripple (all ones plus one), and subtraction with A above, equal to and below B. These cases show whether the carry is preset and chained correctly and whether the final carry is captured as the flag. Add-with-carry runs after a logic operation, so a flag that a logic operation disturbed shows up in the sum. Increment and decrement run with a busy `in_b`, which catches a wrong operand select. A long run of pseudo-random requests with irregular `res_ready` back-pressure separates correct stalling from bits that are skipped or repeated.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_ADC = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_NEG = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    RS_SUM = 2'd0,
    RS_AND = 2'd1,
    RS_OR  = 2'd2,
    RS_XOR = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    BS_MEM   = 2'd0,
    BS_CONST = 2'd1,
    BS_ZERO  = 2'd2
  } b_src_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'd0,
    CI_ONE  = 2'd1,
    CI_FLAG = 2'd2
  } cin_src_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    res_sel_e sel;
    b_src_e   b_src;
    cin_src_e cin_src;
    logic     upd_flag;
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_op(input logic [3:0] op);
    alu_ctrl_t c;
    c = '{inv_a: 1'b0, inv_b: 1'b0, sel: RS_SUM, b_src: BS_MEM,
          cin_src: CI_ZERO, upd_flag: 1'b1};
    case (op)
      OP_SUB: begin c.inv_b = 1'b1; c.cin_src = CI_ONE; end
      OP_ADC: c.cin_src = CI_FLAG;
      OP_SBB: begin c.inv_b = 1'b1; c.cin_src = CI_FLAG; end
      OP_AND: begin c.sel = RS_AND; c.upd_flag = 1'b0; end
      OP_OR:  begin c.sel = RS_OR;  c.upd_flag = 1'b0; end
      OP_XOR: begin c.sel = RS_XOR; c.upd_flag = 1'b0; end
      OP_NEG: begin c.inv_a = 1'b1; c.b_src = BS_ZERO; end
      OP_INC: c.b_src = BS_CONST;
      OP_DEC: begin c.b_src = BS_CONST; c.inv_b = 1'b1; c.cin_src = CI_ONE; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_operand_shreg.sv
module alu_operand_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         lsb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import serial_alu_pkg::*;
(
  input  logic     a,
  input  logic     b,
  input  logic     cin,
  input  logic     inv_a,
  input  logic     inv_b,
  input  res_sel_e sel,
  output logic     res,
  output logic     cout
);
  logic ai, bi, half;

  assign ai   = a ^ inv_a;
  assign bi   = b ^ inv_b;
  assign half = ai ^ bi;
  assign cout = (ai & bi) | (cin & half);

  always_comb begin
    unique case (sel)
      RS_AND:  res = ai & bi;
      RS_OR:   res = ai | bi;
      RS_XOR:  res = half;
      default: res = half ^ cin;
    endcase
  end
endmodule

// File: rtl/alu_sequencer.sv
module alu_sequencer #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic res_valid,
  input  logic res_ready,
  output logic res_last,
  output logic load,
  output logic step,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign in_ready  = !busy_q;
  assign res_valid = busy_q;
  assign res_last  = busy_q && (cnt_q == LAST);
  assign load      = in_valid && !busy_q;
  assign step      = busy_q && res_ready;
  assign done      = step && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (step) begin
      busy_q <= !done;
      cnt_q  <= done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/serial_alu_core.sv
module serial_alu_core
  import serial_alu_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [KW-1:0] in_k,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_bit,
  output logic          res_last,
  output logic          carry_flag
);
  localparam int NOPND = 2;

  logic      load, step, done;
  alu_ctrl_t ctrl_q, ctrl_d;
  logic      carry_q, flag_q, cin_preset, cout;
  logic [W-1:0] b_word;
  logic [W-1:0] opnd_din [NOPND];
  logic         opnd_lsb [NOPND];

  alu_sequencer #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_last(res_last),
    .load(load), .step(step), .done(done)
  );

  assign ctrl_d = decode_op(in_op);

  always_comb begin
    unique case (ctrl_d.b_src)
      BS_CONST: b_word = {{(W-KW){1'b0}}, in_k};
      BS_ZERO:  b_word = '0;
      default:  b_word = in_b;
    endcase
    unique case (ctrl_d.cin_src)
      CI_ONE:  cin_preset = 1'b1;
      CI_FLAG: cin_preset = flag_q;
      default: cin_preset = 1'b0;
    endcase
  end

  assign opnd_din[0] = in_a;
  assign opnd_din[1] = b_word;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    alu_operand_shreg #(.W(W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
      .din(opnd_din[g]), .lsb(opnd_lsb[g])
    );
  end

  alu_bit_slice u_slice (
    .a(opnd_lsb[0]), .b(opnd_lsb[1]), .cin(carry_q),
    .inv_a(ctrl_q.inv_a), .inv_b(ctrl_q.inv_b), .sel(ctrl_q.sel),
    .res(res_bit), .cout(cout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      carry_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (load) begin
        ctrl_q  <= ctrl_d;
        carry_q <= cin_preset;
      end else if (step) begin
        carry_q <= cout;
      end
      if (done && ctrl_q.upd_flag) flag_q <= cout;
    end
  end

  assign carry_flag = flag_q;
endmodule

// File: rtl/serial_alu_core_chk.sv
module serial_alu_core_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic res_valid,
  input logic res_ready,
  input logic res_bit,
  input logic res_last,
  input logic carry_flag
);
  localparam int BW = $clog2(W) + 1;
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        beat_q <= '0;
    else if (in_valid && in_ready)     beat_q <= '0;
    else if (res_valid && res_ready)   beat_q <= beat_q + 1'b1;
  end

  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && res_valid));

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_last) |=> in_ready);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  p_last_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (beat_q == BW'(W - 1))));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_bit) && $stable(res_last)));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_ready && res_last) |=> $stable(carry_flag));
endmodule

bind serial_alu_core serial_alu_core_chk #(.W(W)) u_chk (.*);

// File: tb/serial_alu_core_bench.sv
`timescale 1ns/1ps
module serial_alu_core_bench;
  localparam int W  = 8;
  localparam int KW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic [KW-1:0] in_k = '0;
  logic res_ready = 1'b1;
  logic in_ready, res_valid, res_bit, res_last, carry_flag;

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  bit stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [W-1:0] exp_res_q [$];
  logic         exp_flag_q [$];
  int           exp_req_q [$];
  logic         model_flag = 1'b0;

  always #2.5 clk = ~clk;

  serial_alu_core #(.W(W), .KW(KW)) u_serial_alu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_k(in_k),
    .res_valid(res_valid), .res_ready(res_ready), .res_bit(res_bit),
    .res_last(res_last), .carry_flag(carry_flag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected result from the requirements: returns {flag, result}
  function automatic logic [W:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic [KW-1:0] k,
                                       input logic f);
    logic [W:0] s;
    logic [W-1:0] kx;
    kx = W'(k);
    case (op)
      4'd1: s = {1'b0, a} + {1'b0, ~b} + 1;
      4'd2: s = {1'b0, a} + {1'b0, b} + f;
      4'd3: s = {1'b0, a} + {1'b0, ~b} + f;
      4'd4: s = {f, a & b};
      4'd5: s = {f, a | b};
      4'd6: s = {f, a ^ b};
      4'd7: s = {1'b0, ~a};
      4'd8: s = {1'b0, a} + {1'b0, kx};
      4'd9: s = {1'b0, a} + {1'b0, ~kx} + 1;
      default: s = {1'b0, a} + {1'b0, b};
    endcase
    return s;
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R5";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [KW-1:0] k);
    logic [W:0] m;
    m = model(op, a, b, k, model_flag);
    model_flag = m[W];
    exp_res_q.push_back(m[W-1:0]);
    exp_flag_q.push_back(m[W]);
    exp_req_q.push_back(int'(op));
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_k = k; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    in_b = ~b;
  endtask

  // back-pressure generator, changes away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    res_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic [W-1:0] acc = '0;
  int  idx = 0;
  bit  flag_pend = 1'b0;
  logic flag_exp = 1'b0;
  bit  prev_stall = 1'b0;
  logic prev_bit = 1'b0, prev_last = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (flag_pend) begin
        check(carry_flag === flag_exp, "R10 flag after packet", carry_flag, flag_exp);
        flag_pend = 1'b0;
      end
      if (prev_stall)
        check(res_valid && res_bit === prev_bit && res_last === prev_last,
              "R4 hold under stall", {res_valid, res_bit, res_last}, {1'b1, prev_bit, prev_last});
      prev_stall = res_valid && !res_ready;
      prev_bit = res_bit; prev_last = res_last;
      if (res_valid && res_ready) begin
        acc[idx] = res_bit;
        if (res_last) begin
          check(idx == W-1, "R3 last on bit W-1", idx, W-1);
          if (exp_res_q.size() == 0) begin
            check(1'b0, "R3 unexpected packet", acc, 0);
          end else begin
            automatic logic [W-1:0] er = exp_res_q.pop_front();
            automatic int op = exp_req_q.pop_front();
            flag_exp = exp_flag_q.pop_front();
            check(acc === er, req_of(4'(op)), acc, er);
            flag_pend = 1'b1;
          end
          idx = 0;
        end else begin
          check(idx < W-1, "R3 missing last", idx, W-1);
          idx++;
        end
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_res_q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    check(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
    check(carry_flag === 1'b0, "R1 carry_flag", carry_flag, 0);

    // R2: accept, then in_ready low until the last bit
    send(4'd0, 8'h12, 8'h34, 3'd0);
    @(negedge clk);
    check(in_ready === 1'b0 && res_valid === 1'b1, "R2 busy after accept",
          {in_ready, res_valid}, 2'b01);

    send(4'd0, 8'hFF, 8'h01, 3'd0);   // R5 full ripple, carry out 1
    send(4'd0, 8'h55, 8'hAA, 3'd0);   // R5 no carries
    send(4'd1, 8'h50, 8'h20, 3'd0);   // R5 A>B
    send(4'd1, 8'h20, 8'h50, 3'd0);   // R5 A<B borrow
    send(4'd1, 8'h77, 8'h77, 3'd0);   // R5 equal
    send(4'd0, 8'h80, 8'h80, 3'd0);   // sets flag
    send(4'd4, 8'hF0, 8'h3C, 3'd0);   // R7 AND keeps flag
    send(4'd2, 8'h10, 8'h01, 3'd0);   // R6 ADC uses kept flag
    send(4'd3, 8'h10, 8'h01, 3'd0);   // R6 SBB
    send(4'd3, 8'h01, 8'h10, 3'd0);   // R6 SBB borrow
    send(4'd5, 8'hF0, 8'h0C, 3'd0);   // R7 OR
    send(4'd6, 8'hFF, 8'h0F, 3'd0);   // R7 XOR
    send(4'd7, 8'h3A, 8'hFF, 3'd0);   // R8 NEG, B ignored
    send(4'd8, 8'hFE, 8'hA5, 3'd5);   // R9 INC with busy B
    send(4'd9, 8'h03, 8'h5A, 3'd7);   // R9 DEC below zero
    send(4'd9, 8'h40, 8'hFF, 3'd1);   // R9 DEC by one
    send(4'd12, 8'h81, 8'h7F, 3'd2);  // R11 undefined code
    send(4'd15, 8'h01, 8'h02, 3'd0);  // R11

    stall_en = 1'b1;                  // R4 back-pressure run
    for (int i = 0; i < 60; i++) begin
      automatic logic [31:0] r = {lfsr, lfsr ^ 16'h5A3C} * 32'd2654435761 + i;
      send(4'(r[3:0] % 10), r[15:8], r[23:16], r[26:24]);
    end

    while (exp_res_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && res_valid === 1'b0, "R2 idle after drain",
          {in_ready, res_valid}, 2'b10);
    finish_run();
  end
endmodule